// File: doc/BRIEF.md
# Streaming Radix-2 Frequency-Decimation Stage

This block performs one radix-2 decimation-in-frequency step on a stream of complex samples, one sample in and one sample out on every clock where the enable is high. The stream is cut into blocks of 2H samples, where H = 2^LG_HALF. A pulse on `in_sync` marks the first sample of a block. The first H samples of a block go into a local buffer. Each of the next H samples is then paired with the buffered sample that came H positions earlier. The pair passes through a pipelined butterfly whose twiddle factor comes from a table built at elaboration.

The butterfly gives two results per pair, but only one output is allowed per enabled clock. The stage forwards the sum result straight away and parks the twiddled difference in an output buffer. It then plays the parked values back while the butterfly works on the buffering half of the next block. A marker travels with the data through the butterfly pipeline and lines up this reordering, so after the first block the output is a continuous stream.

The stage is meant to be used in one branch of a transform whose samples are split into even and odd streams. The full transform size is 4H, and the `ODD` parameter chooses the odd-indexed twiddles.

Top module: `dif_stage`

## Requirements
- R1: After a synchronous reset, `out_sync` is 0 and `out_data` is all zeros.
- R2: Enabled input samples that arrive before the first `in_sync` since reset are discarded: `out_sync` stays 0 and `out_data` keeps its reset value.
- R3: Count the enabled edge that samples `in_sync` as edge 1. Output sample 0 of that block appears after enabled edge H+BF_LAT+1, and `out_sync` stays 0 before then.
- R4: Output samples j = 0..H-1 of a block equal a+b, where a is input j and b is input j+H. Each part is sign-extended to IW+2 bits. In every word the real part sits in the upper half and the imaginary part in the lower half, both two's complement.
- R5: Output samples j = H..2H-1 equal (a-b)·(c - i·s), with k = j-H, a = input k and b = input k+H. The real part is ((ar-br)·c + (ai-bi)·s) >>> (CW-2). The imaginary part is ((ai-bi)·c - (ar-br)·s) >>> (CW-2). Both shifts are arithmetic (floor), and each result is kept to IW+2 bits.
- R6: The twiddle index is n = 2k when ODD=0 and n = 2k+1 when ODD=1. The values are c = floor(2^(CW-2)·cos(2πn/(4H)) + 1/2) and s = floor(2^(CW-2)·sin(2πn/(4H)) + 1/2).
- R7: `out_sync` is 1 exactly with output sample 0 of each block and is 0 with every other output sample.
- R8: Once output has started and blocks keep arriving back to back, every enabled edge delivers the next output sample in order, with no gaps.
- R9: While `ce` is low, no state moves: `out_data` and `out_sync` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; gates every register |
| in_sync | input | 1 | Marks the first sample of an input block |
| in_data | input | 2*IW | Complex input sample: real part in upper half, imaginary part in lower half |
| out_sync | output | 1 | Marks output sample 0 of a block |
| out_data | output | 2*(IW+2) | Complex output sample, same packing as the input |

## Verification
The bench checks the exact enabled edge on which the first sync appears. If the marker were delayed by the wrong number of stages, the sum and difference halves would be swapped, or the marker would land one sample early or late. Enable stalls are placed in the middle of blocks: a stage that advanced any counter or pipe register while disabled would lose its alignment from that point on. The bench also drives full-scale values of opposite signs, which show up truncated sums or a floor shift done as truncation toward zero. A second instance with odd twiddles would expose a table indexed by 2k when 2k+1 is required.

// File: rtl/dif_stage_pkg.sv
package dif_stage_pkg;

    localparam real PI_C = 3.14159265358979323846;

    // Taylor-series sine, evaluated at elaboration time only
    function automatic real sine_series(input real x_in);
        real x;
        real term;
        real acc;
        x = x_in;
        while (x > PI_C)  x = x - 2.0 * PI_C;
        while (x < -PI_C) x = x + 2.0 * PI_C;
        term = x;
        acc  = x;
        for (int i = 1; i < 14; i++) begin
            term = -term * x * x / (real'(2 * i) * real'(2 * i + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    function automatic int round_half_up(input real v);
        real r;
        int  t;
        r = v + 0.5;
        t = $rtoi(r);
        if (r < 0.0 && real'(t) != r) t = t - 1;
        return t;
    endfunction

    function automatic int twiddle_re(input int n, input int npts, input int fbits);
        real ang;
        ang = 2.0 * PI_C * real'(n) / real'(npts);
        return round_half_up(sine_series(ang + PI_C / 2.0) * real'(1 << fbits));
    endfunction

    function automatic int twiddle_im(input int n, input int npts, input int fbits);
        real ang;
        ang = 2.0 * PI_C * real'(n) / real'(npts);
        return round_half_up(sine_series(ang) * real'(1 << fbits));
    endfunction

endpackage

// File: rtl/dif_twiddle_rom.sv
module dif_twiddle_rom #(
    parameter int LG_HALF = 2,
    parameter int CW      = 10,
    parameter bit ODD     = 1'b0
) (
    input  logic [LG_HALF-1:0]   idx,
    output logic signed [CW-1:0] cos_o,
    output logic signed [CW-1:0] sin_o
);
    localparam int HALF = 1 << LG_HALF;
    localparam int NPTS = 4 * HALF;
    localparam int FB   = CW - 2;
    localparam int OFS  = ODD ? 1 : 0;

    logic signed [CW-1:0] cos_tab [HALF];
    logic signed [CW-1:0] sin_tab [HALF];

    // R6: even branch uses n = 2k, odd branch n = 2k+1
    for (genvar k = 0; k < HALF; k++) begin : g_entry
        localparam int NIDX = 2 * k + OFS;
        localparam int CVAL = dif_stage_pkg::twiddle_re(NIDX, NPTS, FB);
        localparam int SVAL = dif_stage_pkg::twiddle_im(NIDX, NPTS, FB);
        assign cos_tab[k] = CVAL[CW-1:0];
        assign sin_tab[k] = SVAL[CW-1:0];
    end

    assign cos_o = cos_tab[idx];
    assign sin_o = sin_tab[idx];
endmodule

// File: rtl/dif_butterfly.sv
module dif_butterfly #(
    parameter int IW     = 8,
    parameter int CW     = 10,
    parameter int BF_LAT = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce,
    input  logic                  in_mark,
    input  logic [2*IW-1:0]       a_in,
    input  logic [2*IW-1:0]       b_in,
    input  logic signed [CW-1:0]  cos_i,
    input  logic signed [CW-1:0]  sin_i,
    output logic                  out_mark,
    output logic [2*(IW+2)-1:0]   sum_o,
    output logic [2*(IW+2)-1:0]   rot_o
);
    localparam int OW  = IW + 2;
    localparam int DW  = 2 * IW;
    localparam int ODW = 2 * OW;
    localparam int PW  = IW + CW + 2;
    localparam int FB  = CW - 2;

    logic signed [IW-1:0] ar, ai, br, bi;
    logic signed [IW:0]   sr, si, dr, di;
    logic signed [PW-1:0] pr, pim;
    logic [ODW-1:0]       sum_w, rot_w;

    always_comb begin
        ar    = $signed(a_in[DW-1:IW]);
        ai    = $signed(a_in[IW-1:0]);
        br    = $signed(b_in[DW-1:IW]);
        bi    = $signed(b_in[IW-1:0]);
        sr    = (IW+1)'(ar) + (IW+1)'(br);
        si    = (IW+1)'(ai) + (IW+1)'(bi);
        dr    = (IW+1)'(ar) - (IW+1)'(br);
        di    = (IW+1)'(ai) - (IW+1)'(bi);
        pr    = PW'(dr) * PW'(cos_i) + PW'(di) * PW'(sin_i);
        pim   = PW'(di) * PW'(cos_i) - PW'(dr) * PW'(sin_i);
        sum_w = {OW'(sr), OW'(si)};
        rot_w = {OW'(pr >>> FB), OW'(pim >>> FB)};
    end

    logic [ODW-1:0] sum_q  [BF_LAT];
    logic [ODW-1:0] rot_q  [BF_LAT];
    logic           mark_q [BF_LAT];

    for (genvar g = 0; g < BF_LAT; g++) begin : g_pipe
        logic [ODW-1:0] sum_d, rot_d;
        logic           mark_d;
        always_comb begin
            if (g == 0) begin
                sum_d  = sum_w;
                rot_d  = rot_w;
                mark_d = in_mark;
            end else begin
                sum_d  = sum_q[(g == 0) ? 0 : g-1];
                rot_d  = rot_q[(g == 0) ? 0 : g-1];
                mark_d = mark_q[(g == 0) ? 0 : g-1];
            end
        end
        always_ff @(posedge clk) begin
            if (rst) mark_q[g] <= 1'b0;
            else if (ce) mark_q[g] <= mark_d;
            if (ce) begin
                sum_q[g] <= sum_d;
                rot_q[g] <= rot_d;
            end
        end
    end

    assign out_mark = mark_q[BF_LAT-1];
    assign sum_o    = sum_q[BF_LAT-1];
    assign rot_o    = rot_q[BF_LAT-1];
endmodule

// File: rtl/dif_stage.sv
module dif_stage #(
    parameter int IW      = 8,
    parameter int CW      = 10,
    parameter int LG_HALF = 2,
    parameter int BF_LAT  = 2,
    parameter bit ODD     = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce,
    input  logic                in_sync,
    input  logic [2*IW-1:0]     in_data,
    output logic                out_sync,
    output logic [2*(IW+2)-1:0] out_data
);
    localparam int HALF  = 1 << LG_HALF;
    localparam int CNT_W = LG_HALF + 1;
    localparam int OW    = IW + 2;
    localparam int DW    = 2 * IW;
    localparam int ODW   = 2 * OW;

    typedef struct packed {
        logic [CNT_W-1:0] in_cnt;
        logic             in_run;
        logic [CNT_W-1:0] out_cnt;
        logic             out_run;
        logic             sync;
        logic [ODW-1:0]   data;
    } state_t;

    state_t st_q, st_d;

    logic [DW-1:0]  hold_mem [HALF];
    logic [ODW-1:0] park_mem [HALF];

    logic             in_act, in_fill, bf_mark_in, out_act, out_early;
    logic [CNT_W-1:0] in_idx, out_idx;
    logic [DW-1:0]    paired;
    logic signed [CW-1:0] tw_c, tw_s;
    logic             bf_mark;
    logic [ODW-1:0]   bf_sum, bf_rot;

    always_comb begin
        in_act     = st_q.in_run | in_sync;
        in_idx     = in_sync ? '0 : st_q.in_cnt;
        in_fill    = ~in_idx[LG_HALF];
        bf_mark_in = in_act && (in_idx == CNT_W'(HALF));
        paired     = hold_mem[in_idx[LG_HALF-1:0]];
        out_act    = st_q.out_run | bf_mark;
        out_idx    = bf_mark ? '0 : st_q.out_cnt;
        out_early  = ~out_idx[LG_HALF];
    end

    dif_twiddle_rom #(.LG_HALF(LG_HALF), .CW(CW), .ODD(ODD)) u_rom (
        .idx   (in_idx[LG_HALF-1:0]),
        .cos_o (tw_c),
        .sin_o (tw_s)
    );

    dif_butterfly #(.IW(IW), .CW(CW), .BF_LAT(BF_LAT)) u_bfly (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .in_mark  (bf_mark_in),
        .a_in     (paired),
        .b_in     (in_data),
        .cos_i    (tw_c),
        .sin_i    (tw_s),
        .out_mark (bf_mark),
        .sum_o    (bf_sum),
        .rot_o    (bf_rot)
    );

    always_comb begin
        st_d = st_q;
        if (ce) begin
            if (in_act) begin
                st_d.in_run = 1'b1;
                st_d.in_cnt = in_idx + 1'b1;
            end
            if (out_act) begin
                st_d.out_run = 1'b1;
                st_d.out_cnt = out_idx + 1'b1;
                st_d.data    = out_early ? bf_sum : park_mem[out_idx[LG_HALF-1:0]];
            end
            st_d.sync = bf_mark;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (ce && in_act && in_fill)    hold_mem[in_idx[LG_HALF-1:0]]  <= in_data;
        if (ce && out_act && out_early) park_mem[out_idx[LG_HALF-1:0]] <= bf_rot;
    end

    assign out_sync = st_q.sync;
    assign out_data = st_q.data;

    // ---------------- assertions ----------------
    logic rst_prev_q;
    always_ff @(posedge clk) rst_prev_q <= rst;

    always @(posedge clk) begin
        if (rst_prev_q && !rst)
            assert_reset_clear_R1: assert (!out_sync && out_data == '0)
                else $error("outputs not cleared by reset");
    end

    assert_presync_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (!st_q.in_run && !in_sync) |=> !out_sync);

    assert_sync_single_R7: assert property (@(posedge clk) disable iff (rst)
        (ce && out_sync) |=> !out_sync);

    assert_stream_stays_R8: assert property (@(posedge clk) disable iff (rst)
        st_q.out_run |=> st_q.out_run);

    assert_hold_on_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(out_data) && $stable(out_sync)));
endmodule

// File: tb/dif_stage_test.sv
module dif_stage_test;
    localparam int IW      = 8;
    localparam int CW      = 10;
    localparam int LG_HALF = 2;
    localparam int BF_LAT  = 2;
    localparam int HALF    = 1 << LG_HALF;
    localparam int BLK     = 2 * HALF;
    localparam int OW      = IW + 2;
    localparam int DW      = 2 * IW;
    localparam int ODW     = 2 * OW;
    localparam int FB      = CW - 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b0;
    logic in_sync = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic out_sync, odd_sync;
    logic [ODW-1:0] out_data, odd_data;

    always #4 clk = ~clk;

    dif_stage #(.IW(IW), .CW(CW), .LG_HALF(LG_HALF), .BF_LAT(BF_LAT), .ODD(1'b0)) uut (
        .clk(clk), .rst(rst), .ce(ce), .in_sync(in_sync), .in_data(in_data),
        .out_sync(out_sync), .out_data(out_data));

    dif_stage #(.IW(IW), .CW(CW), .LG_HALF(LG_HALF), .BF_LAT(BF_LAT), .ODD(1'b1)) uut_odd (
        .clk(clk), .rst(rst), .ce(ce), .in_sync(in_sync), .in_data(in_data),
        .out_sync(odd_sync), .out_data(odd_data));

    int checks = 0;
    int errs   = 0;
    logic [DW-1:0] xs [1024];
    int  en_cnt;
    int  t0;
    bit  run;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [ODW-1:0] model(input bit odd, input int base, input int j);
        int k, ar, ai, br, bi, rr, ri, c, s, n;
        longint pr, pm;
        real sc, ang;
        k  = j % HALF;
        ar = $signed(xs[base+k][DW-1:IW]);
        ai = $signed(xs[base+k][IW-1:0]);
        br = $signed(xs[base+k+HALF][DW-1:IW]);
        bi = $signed(xs[base+k+HALF][IW-1:0]);
        if (j < HALF) begin
            rr = ar + br;
            ri = ai + bi;
        end else begin
            n   = 2 * k + (odd ? 1 : 0);
            sc  = real'(1 << FB);
            ang = 2.0 * 3.14159265358979323846 * real'(n) / real'(4 * HALF);
            c   = int'($floor(sc * $cos(ang) + 0.5));
            s   = int'($floor(sc * $sin(ang) + 0.5));
            pr  = longint'(ar - br) * c + longint'(ai - bi) * s;
            pm  = longint'(ai - bi) * c - longint'(ar - br) * s;
            rr  = int'(pr >>> FB);
            ri  = int'(pm >>> FB);
        end
        return {OW'(rr), OW'(ri)};
    endfunction

    task automatic step(input bit e, input bit sy, input logic [DW-1:0] d);
        logic [ODW-1:0] p_data, p_odd;
        logic p_sync, p_osync;
        int g, base, j;
        logic [ODW-1:0] ev, ov;
        ce = e; in_sync = sy; in_data = d;
        p_data = out_data; p_odd = odd_data; p_sync = out_sync; p_osync = odd_sync;
        @(posedge clk);
        #1;
        if (!e) begin
            // R9: nothing moves while disabled
            chk(out_data == p_data && out_sync == p_sync, "R9 hold even", {out_sync, out_data}, {p_sync, p_data});
            chk(odd_data == p_odd && odd_sync == p_osync, "R9 hold odd", {odd_sync, odd_data}, {p_osync, p_odd});
        end else begin
            en_cnt++;
            if (!run && sy) begin
                run = 1'b1;
                t0  = en_cnt;
            end
            if (run) xs[en_cnt - t0] = d;
            g = en_cnt - t0 - HALF - BF_LAT;
            if (run && g >= 0) begin
                base = (g / BLK) * BLK;
                j    = g % BLK;
                ev   = model(1'b0, base, j);
                ov   = model(1'b1, base, j);
                chk(out_sync == (j == 0), "R7 sync even", 64'(out_sync), 64'(j == 0));
                chk(odd_sync == (j == 0), "R7 sync odd", 64'(odd_sync), 64'(j == 0));
                if (j < HALF)
                    chk(out_data == ev && odd_data == ov, "R4 R8 sum half", {out_data, odd_data}, {ev, ov});
                else begin
                    chk(out_data == ev, "R5 R8 rotated half", out_data, ev);
                    chk(odd_data == ov, "R6 odd twiddles", odd_data, ov);
                end
            end else if (run) begin
                chk(!out_sync && !odd_sync, "R3 no early sync", {odd_sync, out_sync}, 0);
            end else begin
                chk(!out_sync && out_data == '0 && odd_data == '0, "R2 presync ignored", {out_sync, out_data}, 0);
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; ce = 1'b0; in_sync = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        run = 1'b0; en_cnt = 0; t0 = 0;
        chk(!out_sync && out_data == '0, "R1 reset even", {out_sync, out_data}, 0);
        chk(!odd_sync && odd_data == '0, "R1 reset odd", {odd_sync, odd_data}, 0);
    endtask

    function automatic logic [DW-1:0] pattern(input int mode, input int i);
        logic [IW-1:0] mx, mn;
        mx = {1'b0, {(IW-1){1'b1}}};
        mn = {1'b1, {(IW-1){1'b0}}};
        case (mode)
            1:       return (i % 2 == 0) ? {mx, mn} : {mn, mx};
            2:       return (i % BLK == 0) ? {mx, {IW{1'b0}}} : '0;
            default: return DW'($urandom);
        endcase
    endfunction

    // Feed nblk back-to-back blocks; gap_pct gives idle cycles mid-stream
    task automatic feed(input int nblk, input int mode, input int gap_pct);
        for (int i = 0; i < nblk * BLK; i++) begin
            while (gap_pct > 0 && ($urandom % 100) < gap_pct)
                step(1'b0, 1'b0, DW'($urandom));
            step(1'b1, (i % BLK) == 0, pattern(mode, i));
        end
    endtask

    task automatic t_reset();
        do_reset();
    endtask

    task automatic t_presync();
        do_reset();
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, DW'($urandom));
        feed(3, 0, 0);
    endtask

    task automatic t_random_stream();
        do_reset();
        feed(6, 0, 0);
    endtask

    task automatic t_extremes();
        do_reset();
        feed(4, 1, 0);
        feed(2, 2, 0);
    endtask

    task automatic t_stall();
        do_reset();
        feed(6, 0, 35);
    endtask

    task automatic t_reset_midrun();
        do_reset();
        feed(1, 0, 0);
        step(1'b1, 1'b1, DW'($urandom));
        step(1'b1, 1'b0, DW'($urandom));
        do_reset();
        feed(2, 0, 0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        #(8 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_presync();
        t_random_stream();
        t_extremes();
        t_stall();
        t_reset_midrun();
        report();
        $finish;
    end
endmodule